// File: doc/BRIEF.md
# Outbound Address Translator with Viewport Programming

This block maps CPU-side addresses onto link-side addresses through a small set of programmable outbound regions. Each region holds a 64-bit base, a 32-bit limit that shares its upper half with the base, a 64-bit target, a 3-bit transaction-type code and an enable bit. A lookup presents a 64-bit CPU address. The block returns a hit flag, the type code of the winning region and the translated address. Lookup is purely combinational.

Software never addresses a region directly. It first writes a viewport register that names a direction and a region index. It then reads and writes a single shared window of registers, and that window acts on the selected region only. Only the outbound direction is built. While the viewport points inbound or past the last region, the window drops writes and reads as zero.

A configuration-type region carries the bus, device and function numbers in its target. The translated address therefore delivers them unchanged in bits 31:16 whenever the offset into the region stays below 64 KiB.

Top module: `ob_xlate`

## Requirements
- R1: After reset, every region is disabled with all fields zero, the viewport reads zero, and every lookup misses.
- R2: The viewport register sits at offset 0x900. Bit 31 selects the direction (1 inbound, 0 outbound) and bits 7:0 select the region index. A read returns exactly those two fields, with all other bits zero.
- R3: With an outbound viewport on a valid region, the window registers read and write that region's fields. The type is in bits 2:0 at 0x904 (memory 0, I/O 2, config type 0 = 4, config type 1 = 5). The enable is bit 31 at 0x908. Base low is at 0x90C and base high at 0x910. The limit is at 0x914. Target low is at 0x918 and target high at 0x91C.
- R4: A read of 0x908 in the cycle after a write returns the enable bit just written. Bit 30 is not stored and reads as zero.
- R5: When the viewport selects inbound, or an index at or above the region count, writes to the window change no region and window reads return zero.
- R6: A region matches when it is enabled, the address is at or above {base high, base low}, and the address is at or below {base high, limit}. Both bounds are inclusive.
- R7: On a hit, the translated address is {target high, target low} + (address − base), modulo 2^64, and the type output is the region's type code.
- R8: When several regions match, the lowest-indexed region wins.
- R9: On a miss, the hit flag, the type and the translated address are all zero.
- R10: For a config region whose target low holds bus in bits 31:24, device in bits 23:19 and function in bits 18:16, a lookup at an offset below 64 KiB returns those fields unchanged in the same bit positions.
- R11: Offsets outside 0x900–0x91C read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| lk_addr | input | 64 | CPU address to translate |
| lk_hit | output | 1 | A region matched |
| lk_type | output | 3 | Type code of the winning region |
| lk_xaddr | output | 64 | Translated address |

## Verification
Lookups are aimed at each side of both region bounds: base, base − 1, the last byte, and the last byte + 1. These separate inclusive from exclusive comparisons and catch a limit check that drops the shared upper half. Two regions that overlap are probed both inside and outside the overlap, and again after the lower-indexed region is disabled. This shows whether priority, rather than programming order, picks the winner. Window accesses made while the viewport points inbound, or past the last region, or at unmapped offsets are each followed by a readback and a lookup on the outbound region. That proves those accesses touched nothing.

// File: rtl/ob_xlate.sv
module ob_xlate #(
  parameter int NREG = 4,
  parameter int AW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [63:0]   lk_addr,
  output logic          lk_hit,
  output logic [2:0]    lk_type,
  output logic [63:0]   lk_xaddr
);

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW-1:0] OFF_VP  = AW'(12'h900);
  localparam logic [AW-1:0] OFF_TY  = AW'(12'h904);
  localparam logic [AW-1:0] OFF_EN  = AW'(12'h908);
  localparam logic [AW-1:0] OFF_BLO = AW'(12'h90C);
  localparam logic [AW-1:0] OFF_BHI = AW'(12'h910);
  localparam logic [AW-1:0] OFF_LIM = AW'(12'h914);
  localparam logic [AW-1:0] OFF_TLO = AW'(12'h918);
  localparam logic [AW-1:0] OFF_THI = AW'(12'h91C);

  logic            vp_dir;
  logic [7:0]      vp_idx;
  logic [NREG-1:0] r_en;
  logic [2:0]      r_type [NREG];
  logic [31:0]     r_blo  [NREG];
  logic [31:0]     r_bhi  [NREG];
  logic [31:0]     r_lim  [NREG];
  logic [31:0]     r_tlo  [NREG];
  logic [31:0]     r_thi  [NREG];

  logic [IW-1:0]   sel;
  logic            sel_ok;
  logic [NREG-1:0] match;
  logic [IW-1:0]   win;

  assign sel    = vp_idx[IW-1:0];
  assign sel_ok = !vp_dir && (int'(vp_idx) < NREG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
      r_en   <= '0;
      for (int i = 0; i < NREG; i++) begin
        r_type[i] <= '0;
        r_blo[i]  <= '0;
        r_bhi[i]  <= '0;
        r_lim[i]  <= '0;
        r_tlo[i]  <= '0;
        r_thi[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == OFF_VP) begin
        vp_dir <= cfg_wdata[31];
        vp_idx <= cfg_wdata[7:0];
      end else if (sel_ok) begin
        case (cfg_addr)
          OFF_TY:  r_type[sel] <= cfg_wdata[2:0];
          OFF_EN:  r_en[sel]   <= cfg_wdata[31];
          OFF_BLO: r_blo[sel]  <= cfg_wdata;
          OFF_BHI: r_bhi[sel]  <= cfg_wdata;
          OFF_LIM: r_lim[sel]  <= cfg_wdata;
          OFF_TLO: r_tlo[sel]  <= cfg_wdata;
          OFF_THI: r_thi[sel]  <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFF_VP)
      cfg_rdata = {vp_dir, 23'b0, vp_idx};
    else if (sel_ok) begin
      case (cfg_addr)
        OFF_TY:  cfg_rdata = {29'b0, r_type[sel]};
        OFF_EN:  cfg_rdata = {r_en[sel], 31'b0};
        OFF_BLO: cfg_rdata = r_blo[sel];
        OFF_BHI: cfg_rdata = r_bhi[sel];
        OFF_LIM: cfg_rdata = r_lim[sel];
        OFF_TLO: cfg_rdata = r_tlo[sel];
        OFF_THI: cfg_rdata = r_thi[sel];
        default: cfg_rdata = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match[g] = r_en[g] &&
                      (lk_addr >= {r_bhi[g], r_blo[g]}) &&
                      (lk_addr <= {r_bhi[g], r_lim[g]});
  end

  always_comb begin
    win = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (match[i]) win = IW'(i);
  end

  assign lk_hit   = |match;
  assign lk_type  = lk_hit ? r_type[win] : 3'd0;
  assign lk_xaddr = lk_hit ? ({r_thi[win], r_tlo[win]} + (lk_addr - {r_bhi[win], r_blo[win]})) : 64'd0;

  AST_EN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFF_EN && sel_ok) |=> (r_en[$past(sel)] == $past(cfg_wdata[31]))); // R4
  AST_INBOUND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && vp_dir && cfg_addr != OFF_VP) |=> $stable(r_en)); // R5
  AST_NO_EN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en == '0) |-> (!lk_hit && lk_xaddr == 64'd0)); // R9
  AST_HIT_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_addr >= {r_bhi[win], r_blo[win]})); // R6
  AST_HIT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_addr <= {r_bhi[win], r_lim[win]})); // R6

endmodule

// File: tb/ob_xlate_tb.sv
module ob_xlate_tb;
  localparam int N = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic [2:0]  lk_type;
  logic [63:0] lk_xaddr;

  int n_chk = 0;
  int n_bad = 0;

  ob_xlate u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_type(lk_type), .lk_xaddr(lk_xaddr));

  always #10 clk = ~clk;

  // behavioural reference state
  logic        m_dir;
  int          m_idx;
  logic        m_en  [N];
  logic [2:0]  m_ty  [N];
  logic [63:0] m_base[N];
  logic [31:0] m_lim [N];
  logic [63:0] m_tgt [N];

  task automatic m_reset();
    m_dir = 0; m_idx = 0;
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_ty[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_tgt[i] = 0;
    end
  endtask

  function automatic bit m_win_ok();
    return !m_dir && m_idx < N;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else if (cfg_we) begin
      if (cfg_addr == 12'h900) begin
        m_dir = cfg_wdata[31]; m_idx = int'(cfg_wdata[7:0]);
      end else if (m_win_ok()) begin
        case (cfg_addr)
          12'h904: m_ty[m_idx] = cfg_wdata[2:0];
          12'h908: m_en[m_idx] = cfg_wdata[31];
          12'h90C: m_base[m_idx][31:0]  = cfg_wdata;
          12'h910: m_base[m_idx][63:32] = cfg_wdata;
          12'h914: m_lim[m_idx] = cfg_wdata;
          12'h918: m_tgt[m_idx][31:0]  = cfg_wdata;
          12'h91C: m_tgt[m_idx][63:32] = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a == 12'h900) return {m_dir, 23'b0, 8'(m_idx)};
    if (!m_win_ok()) return 0;
    case (a)
      12'h904: return {29'b0, m_ty[m_idx]};
      12'h908: return {m_en[m_idx], 31'b0};
      12'h90C: return m_base[m_idx][31:0];
      12'h910: return m_base[m_idx][63:32];
      12'h914: return m_lim[m_idx];
      12'h918: return m_tgt[m_idx][31:0];
      12'h91C: return m_tgt[m_idx][63:32];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit h; logic [2:0] t; logic [63:0] x;
      h = 0; t = 0; x = 0;
      for (int i = 0; i < N; i++)
        if (!h && m_en[i] && lk_addr >= m_base[i] && lk_addr <= {m_base[i][63:32], m_lim[i]}) begin
          h = 1; t = m_ty[i]; x = m_tgt[i] + (lk_addr - m_base[i]);
        end
      chk("R6/R8 model hit", 64'(lk_hit), 64'(h));
      chk("R7 model type", 64'(lk_type), 64'(t));
      chk("R7/R9 model xaddr", lk_xaddr, x);
      chk("R3 model rdata", 64'(cfg_rdata), 64'(m_read(cfg_addr)));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    cfg_addr = a; @(negedge clk); chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic look(string tag, logic [63:0] a, logic h, logic [2:0] t, logic [63:0] x);
    lk_addr = a; @(negedge clk);
    chk({tag, " hit"}, 64'(lk_hit), 64'(h));
    chk({tag, " type"}, 64'(lk_type), 64'(t));
    chk({tag, " xaddr"}, lk_xaddr, x);
  endtask

  task automatic prog(int idx, logic [2:0] ty, logic [63:0] base, logic [31:0] lim, logic [63:0] tgt);
    wr(12'h900, 32'(idx));
    wr(12'h904, 32'(ty));
    wr(12'h90C, base[31:0]); wr(12'h910, base[63:32]);
    wr(12'h914, lim);
    wr(12'h918, tgt[31:0]);  wr(12'h91C, tgt[63:32]);
    wr(12'h908, 32'h8000_0000);
  endtask

  bit done = 0;

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    rd("R1 viewport after reset", 12'h900, 0);
    rd("R1 enable after reset", 12'h908, 0);
    look("R1 lookup after reset", 64'h1_0000_0000, 0, 0, 0);

    prog(0, 3'd0, 64'h1_0000_0000, 32'h0000_FFFF, 64'h8000_0000);
    rd("R3 base high", 12'h910, 32'h1);
    rd("R3 limit", 12'h914, 32'h0000_FFFF);
    rd("R3 target low", 12'h918, 32'h8000_0000);
    wr(12'h908, 32'hC000_0000);
    rd("R4 enable readback, bit30 dropped", 12'h908, 32'h8000_0000);

    look("R6 at base", 64'h1_0000_0000, 1, 0, 64'h8000_0000);
    look("R6 at last byte", 64'h1_0000_FFFF, 1, 0, 64'h8000_FFFF);
    look("R6 past limit", 64'h1_0001_0000, 0, 0, 0);
    look("R9 below base", 64'h0_FFFF_FFFF, 0, 0, 0);

    prog(1, 3'd2, 64'h1_0000_8000, 32'h0001_7FFF, 64'h1000);
    look("R8 overlap low index wins", 64'h1_0000_9000, 1, 0, 64'h8000_9000);
    look("R7 region1 only", 64'h1_0001_0000, 1, 3'd2, 64'h9000);
    wr(12'h900, 0); wr(12'h908, 0);
    rd("R4 disable readback", 12'h908, 0);
    look("R8 after low region off", 64'h1_0000_9000, 1, 3'd2, 64'h2000);

    prog(2, 3'd5, 64'h4000_0000, 32'h4000_FFFF, 64'h032A_0000);
    look("R10 config bus/dev/fn", 64'h4000_0010, 1, 3'd5, 64'h032A_0010);

    wr(12'h900, 32'h8000_0002);
    rd("R2 viewport inbound readback", 12'h900, 32'h8000_0002);
    wr(12'h908, 0); wr(12'h90C, 32'h1234);
    rd("R5 inbound window reads zero", 12'h908, 0);
    wr(12'h900, 32'h7FFF_FF02);
    rd("R2 viewport masks other bits", 12'h900, 32'h0000_0002);
    rd("R5 inbound write ignored enable", 12'h908, 32'h8000_0000);
    rd("R5 inbound write ignored base", 12'h90C, 32'h4000_0000);
    look("R5 region still hits", 64'h4000_0020, 1, 3'd5, 64'h032A_0020);

    wr(12'h900, 32'h7); wr(12'h908, 32'h8000_0000); wr(12'h904, 3'd4);
    rd("R5 out-of-range reads zero", 12'h904, 0);
    wr(12'h900, 32'h3);
    rd("R5 region3 untouched", 12'h908, 0);
    look("R5 no stray hit", 64'h0, 0, 0, 0);

    wr(12'h900, 32'h2);
    wr(12'h920, 32'hFFFF_FFFF); wr(12'h8FC, 32'hFFFF_FFFF);
    rd("R11 unmapped read zero", 12'h920, 0);
    rd("R11 type unchanged", 12'h904, 32'd5);
    rd("R11 limit unchanged", 12'h914, 32'h4000_FFFF);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule